// File: doc/BRIEF.md
# Count Threshold Event Detector

This block watches a signed count produced elsewhere and reports when that count arrives at any of five watched values. The watched values are zero, an upper limit, a lower limit and two free thresholds. Each comparison has its own enable. A comparison fires only in the cycle in which the count moves onto its value. A count that stays on the value does not fire again.

When any comparison fires, the block sets an interrupt request. It also captures which comparisons matched, and it keeps those captured flags until software acknowledges the interrupt. A hit on either limit also produces a one-cycle request for the external counter to return to zero. Separately, the block keeps a 2-bit zero-mode status that reports the sign of the count and whether zero was last reached from above or from below.

The configuration is held in local registers. These load together from a single write strobe, and the counter and the bus decode stay outside the block.

Top module: `cnt_evt_detect`

## Requirements
- R1: After reset, all of the following are 0: the captured flags, the raw and masked interrupts, the limit reset request and the zero-mode status. The comparison enables reset to zero=1, upper=1, lower=1, threshold0=0, threshold1=0, and all four programmed values reset to 0.
- R2: An enabled comparison hits in the cycle in which `count_i` changes to a value equal to its programmed value (zero for the zero comparison). The outputs show the hit one clock edge later.
- R3: No comparison hits while `count_i` is unchanged from its previous sampled value, even when that value is equal to a programmed value.
- R4: A comparison whose enable bit is 0 never hits. The enable bit positions are 0 for zero, 1 for upper limit, 2 for lower limit, 3 for threshold0 and 4 for threshold1.
- R5: `count_rst_o` is high for the one cycle after the edge at which the upper or lower limit comparison hits, and is low otherwise.
- R6: Any hit sets `irq_raw_o`. The flag bits in `evt_flags_o` use the same positions as R4.
- R7: While `irq_raw_o` is set and no clear is applied, `evt_flags_o` keeps its value, even if new hits occur.
- R8: A pulse on `irq_clr_i` clears `irq_raw_o` and `evt_flags_o`. If a hit occurs in the same cycle as the clear, `irq_raw_o` stays set and the flags take the new hit pattern.
- R9: `irq_st_o` equals `irq_raw_o` AND the interrupt enable. The interrupt enable resets to 0.
- R10: `zero_mode_o` takes the value 3 when the sampled count is positive and 2 when it is negative. When the count changes to zero, it takes 0 if the previous count was positive and 1 if it was negative. A count that stays at zero keeps the previous value.
- R11: A cycle with `cfg_wr_i` high loads all enables, the four values and the interrupt enable at once. The new configuration governs comparisons from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| count_i | input | 16 | Signed count under observation |
| cfg_wr_i | input | 1 | Load strobe for all configuration fields |
| cfg_cmp_en_i | input | 5 | Comparison enables, bit order as R4 |
| cfg_thr0_i | input | 16 | Threshold 0 value (signed) |
| cfg_thr1_i | input | 16 | Threshold 1 value (signed) |
| cfg_hlim_i | input | 16 | Upper limit value (signed) |
| cfg_llim_i | input | 16 | Lower limit value (signed) |
| cfg_irq_en_i | input | 1 | Interrupt enable |
| irq_clr_i | input | 1 | Write-one-to-clear pulse for the interrupt |
| count_rst_o | output | 1 | One-cycle request to zero the external count |
| evt_flags_o | output | 5 | Captured hit flags, bit order as R4 |
| zero_mode_o | output | 2 | Sign and zero-approach status, encoding as R10 |
| irq_raw_o | output | 1 | Raw interrupt |
| irq_st_o | output | 1 | Masked interrupt |

## Verification
The assertions check the following on every cycle: any hit sets the raw interrupt, the flags hold while the interrupt is pending, a clear without a hit empties both the interrupt and the flags, a limit reset request never appears without a raised interrupt, and the positive zero-mode code follows a positive count. The bench scenarios are needed for the rest. These are the reset defaults, the rule that a value which only persists produces no hit, the precedence of a hit over a clear in the same cycle, the direction of approach to zero, and the behaviour under every combination of enables. To cover that last point, the bench walks the count up and down across all programmed values for every one of the 32 enable masks.

// File: rtl/cnt_evt_pkg.sv
// Shared constants and types for the count threshold event detector.
// Assumes five comparison slots in a fixed order that the flag outputs expose.
package cnt_evt_pkg;
    localparam int CMP_N = 5;

    // Slot order, shared by the enable bits and the captured flags.
    localparam int SLOT_ZERO = 0;
    localparam int SLOT_HLIM = 1;
    localparam int SLOT_LLIM = 2;
    localparam int SLOT_THR0 = 3;
    localparam int SLOT_THR1 = 4;

    // Reset value of the comparison enables: zero and both limits on.
    localparam logic [CMP_N-1:0] EN_RESET = 5'b00111;

    typedef enum logic [1:0] {
        ZM_FELL = 2'd0,   // reached zero from a positive count
        ZM_ROSE = 2'd1,   // reached zero from a negative count
        ZM_NEG  = 2'd2,   // count is negative
        ZM_POS  = 2'd3    // count is positive
    } zero_mode_e;
endpackage

// File: rtl/cnt_evt_cfg.sv
// Configuration holding registers. All fields load together on wr_i.
// Assumes the bus decode outside produces a single-cycle write strobe.
module cnt_evt_cfg
    import cnt_evt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_i,
    input  logic [CMP_N-1:0]        en_i,
    input  logic signed [CNT_W-1:0] thr0_i,
    input  logic signed [CNT_W-1:0] thr1_i,
    input  logic signed [CNT_W-1:0] hlim_i,
    input  logic signed [CNT_W-1:0] llim_i,
    input  logic                    irq_en_i,
    output logic [CMP_N-1:0]        en_o,
    output logic signed [CNT_W-1:0] thr0_o,
    output logic signed [CNT_W-1:0] thr1_o,
    output logic signed [CNT_W-1:0] hlim_o,
    output logic signed [CNT_W-1:0] llim_o,
    output logic                    irq_en_o
);
    logic [CMP_N-1:0]        en_q;
    logic signed [CNT_W-1:0] thr0_q, thr1_q, hlim_q, llim_q;
    logic                    irq_en_q;

    // Load every field on a write, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= EN_RESET;
            thr0_q   <= '0;
            thr1_q   <= '0;
            hlim_q   <= '0;
            llim_q   <= '0;
            irq_en_q <= 1'b0;
        end else if (wr_i) begin
            en_q     <= en_i;
            thr0_q   <= thr0_i;
            thr1_q   <= thr1_i;
            hlim_q   <= hlim_i;
            llim_q   <= llim_i;
            irq_en_q <= irq_en_i;
        end
    end

    assign en_o     = en_q;
    assign thr0_o   = thr0_q;
    assign thr1_o   = thr1_q;
    assign hlim_o   = hlim_q;
    assign llim_o   = llim_q;
    assign irq_en_o = irq_en_q;

    // R11: without a write, the enables hold.
    p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(en_q));
endmodule

// File: rtl/cnt_evt_track.sv
// Keeps the previously sampled count and the zero-mode status.
// Assumes the count is sampled once per clock edge.
module cnt_evt_track
    import cnt_evt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [CNT_W-1:0] count_i,
    output logic signed [CNT_W-1:0] prev_o,
    output zero_mode_e              mode_o
);
    logic signed [CNT_W-1:0] prev_q;
    zero_mode_e              mode_q;

    // Record the last count and classify its sign or zero approach.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            mode_q <= ZM_FELL;
        end else begin
            prev_q <= count_i;
            if (count_i > 0)
                mode_q <= ZM_POS;
            else if (count_i < 0)
                mode_q <= ZM_NEG;
            else if (count_i != prev_q)
                mode_q <= (prev_q > 0) ? ZM_FELL : ZM_ROSE;
        end
    end

    assign prev_o = prev_q;
    assign mode_o = mode_q;

    // R10: the positive code only follows a positive sampled count.
    p_zm_pos_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == ZM_POS) |-> ($past(count_i) > 0));
endmodule

// File: rtl/cnt_evt_cmp.sv
// Bank of equality comparisons. A slot hits only when enabled and when
// the count changed onto its value in this cycle.
// Assumes ref_i slot 0 carries the constant zero.
module cnt_evt_cmp
    import cnt_evt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic signed [CNT_W-1:0]  count_i,
    input  logic signed [CNT_W-1:0]  prev_i,
    input  logic [CMP_N-1:0]         en_i,
    input  logic [CMP_N-1:0][CNT_W-1:0] ref_i,
    output logic [CMP_N-1:0]         hit_o
);
    logic moved;

    // The count left its previous value.
    assign moved = (count_i != prev_i);

    for (genvar s = 0; s < CMP_N; s++) begin : g_slot
        // One slot: enabled, moved, and equal.
        always_comb hit_o[s] = en_i[s] && moved && (count_i == ref_i[s]);
    end
endmodule

// File: rtl/cnt_evt_irq.sv
// Interrupt and capture logic: raw bit, masked status, captured hit
// flags and the limit reset request.
// Assumes clr_i is a single-cycle write-one pulse.
module cnt_evt_irq
    import cnt_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CMP_N-1:0] hit_i,
    input  logic             clr_i,
    input  logic             irq_en_i,
    output logic             raw_o,
    output logic             st_o,
    output logic [CMP_N-1:0] flags_o,
    output logic             rst_req_o
);
    logic             raw_q;
    logic [CMP_N-1:0] flags_q;
    logic             rst_req_q;
    logic             any_hit;

    // Any slot hit this cycle.
    assign any_hit = |hit_i;

    // Raw bit: set by a hit, cleared by a clear, hit wins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            raw_q <= 1'b0;
        else if (any_hit)
            raw_q <= 1'b1;
        else if (clr_i)
            raw_q <= 1'b0;
    end

    // Flags capture the hit pattern when no interrupt is pending or on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_q <= '0;
        else if (any_hit && (!raw_q || clr_i))
            flags_q <= hit_i;
        else if (clr_i)
            flags_q <= '0;
    end

    // One-cycle request to zero the count on a limit hit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rst_req_q <= 1'b0;
        else
            rst_req_q <= hit_i[SLOT_HLIM] | hit_i[SLOT_LLIM];
    end

    assign raw_o     = raw_q;
    assign st_o      = raw_q & irq_en_i;
    assign flags_o   = flags_q;
    assign rst_req_o = rst_req_q;

    // R6: a hit always leaves the raw bit set.
    p_raw_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |=> raw_q);
    // R7: pending flags are stable until cleared.
    p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_q && !clr_i) |=> $stable(flags_q));
    // R8: a clear without a hit empties raw and flags.
    p_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !any_hit) |=> (!raw_q && flags_q == '0));
endmodule

// File: rtl/cnt_evt_detect.sv
// Top of the count threshold event detector. Wires the configuration
// registers, count tracker, comparison bank and interrupt logic.
// Assumes the count comes from an external counter in the same clock domain.
module cnt_evt_detect
    import cnt_evt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [CNT_W-1:0] count_i,
    input  logic                    cfg_wr_i,
    input  logic [CMP_N-1:0]        cfg_cmp_en_i,
    input  logic signed [CNT_W-1:0] cfg_thr0_i,
    input  logic signed [CNT_W-1:0] cfg_thr1_i,
    input  logic signed [CNT_W-1:0] cfg_hlim_i,
    input  logic signed [CNT_W-1:0] cfg_llim_i,
    input  logic                    cfg_irq_en_i,
    input  logic                    irq_clr_i,
    output logic                    count_rst_o,
    output logic [CMP_N-1:0]        evt_flags_o,
    output logic [1:0]              zero_mode_o,
    output logic                    irq_raw_o,
    output logic                    irq_st_o
);
    logic [CMP_N-1:0]           en;
    logic signed [CNT_W-1:0]    thr0, thr1, hlim, llim, prev;
    logic                       irq_en;
    logic [CMP_N-1:0][CNT_W-1:0] refs;
    logic [CMP_N-1:0]           hit;
    zero_mode_e                 mode;

    cnt_evt_cfg #(.CNT_W(CNT_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_i(cfg_wr_i),
        .en_i(cfg_cmp_en_i), .thr0_i(cfg_thr0_i), .thr1_i(cfg_thr1_i),
        .hlim_i(cfg_hlim_i), .llim_i(cfg_llim_i), .irq_en_i(cfg_irq_en_i),
        .en_o(en), .thr0_o(thr0), .thr1_o(thr1),
        .hlim_o(hlim), .llim_o(llim), .irq_en_o(irq_en)
    );

    cnt_evt_track #(.CNT_W(CNT_W)) u_track (
        .clk(clk), .rst_n(rst_n), .count_i(count_i),
        .prev_o(prev), .mode_o(mode)
    );

    // Collect the reference values in slot order.
    always_comb begin
        refs[SLOT_ZERO] = '0;
        refs[SLOT_HLIM] = hlim;
        refs[SLOT_LLIM] = llim;
        refs[SLOT_THR0] = thr0;
        refs[SLOT_THR1] = thr1;
    end

    cnt_evt_cmp #(.CNT_W(CNT_W)) u_cmp (
        .count_i(count_i), .prev_i(prev), .en_i(en),
        .ref_i(refs), .hit_o(hit)
    );

    cnt_evt_irq u_irq (
        .clk(clk), .rst_n(rst_n), .hit_i(hit), .clr_i(irq_clr_i),
        .irq_en_i(irq_en), .raw_o(irq_raw_o), .st_o(irq_st_o),
        .flags_o(evt_flags_o), .rst_req_o(count_rst_o)
    );

    assign zero_mode_o = mode;

    // R5: a limit reset request always comes with a raised interrupt.
    p_rst_raw_r5: assert property (@(posedge clk) disable iff (!rst_n)
        count_rst_o |-> irq_raw_o);
endmodule

// File: tb/cnt_evt_detect_tb.sv
module cnt_evt_detect_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic signed [15:0] count_i = '0;
    logic cfg_wr_i = 1'b0;
    logic [4:0] cfg_cmp_en_i = '0;
    logic signed [15:0] cfg_thr0_i = '0, cfg_thr1_i = '0, cfg_hlim_i = '0, cfg_llim_i = '0;
    logic cfg_irq_en_i = 1'b0;
    logic irq_clr_i = 1'b0;
    logic count_rst_o, irq_raw_o, irq_st_o;
    logic [4:0] evt_flags_o;
    logic [1:0] zero_mode_o;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // model state
    logic signed [15:0] m_prev, m_t0, m_t1, m_hl, m_ll;
    logic [4:0] m_en, m_flags;
    logic m_raw, m_rst, m_ie;
    logic [1:0] m_zm;

    always #10 clk = ~clk;

    cnt_evt_detect u_dut (
        .clk(clk), .rst_n(rst_n), .count_i(count_i), .cfg_wr_i(cfg_wr_i),
        .cfg_cmp_en_i(cfg_cmp_en_i), .cfg_thr0_i(cfg_thr0_i), .cfg_thr1_i(cfg_thr1_i),
        .cfg_hlim_i(cfg_hlim_i), .cfg_llim_i(cfg_llim_i), .cfg_irq_en_i(cfg_irq_en_i),
        .irq_clr_i(irq_clr_i), .count_rst_o(count_rst_o), .evt_flags_o(evt_flags_o),
        .zero_mode_o(zero_mode_o), .irq_raw_o(irq_raw_o), .irq_st_o(irq_st_o)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    // Reference model for one clock edge.
    task automatic model(input logic signed [15:0] v, input logic clr);
        logic moved;
        logic [4:0] h;
        moved = (v != m_prev);
        h[0] = m_en[0] && moved && (v == 0);
        h[1] = m_en[1] && moved && (v == m_hl);
        h[2] = m_en[2] && moved && (v == m_ll);
        h[3] = m_en[3] && moved && (v == m_t0);
        h[4] = m_en[4] && moved && (v == m_t1);
        m_rst = h[1] | h[2];
        if ((h != 0) && (!m_raw || clr)) m_flags = h;
        else if (clr) m_flags = '0;
        m_raw = (h != 0) | (m_raw & ~clr);
        if (v > 0) m_zm = 2'd3;
        else if (v < 0) m_zm = 2'd2;
        else if (moved) m_zm = (m_prev > 0) ? 2'd0 : 2'd1;
        m_prev = v;
    endtask

    task automatic compare();
        chk("R5", "count_rst_o", int'(count_rst_o), int'(m_rst));
        chk("R6", "irq_raw_o", int'(irq_raw_o), int'(m_raw));
        chk("R7", "evt_flags_o", int'(evt_flags_o), int'(m_flags));
        chk("R9", "irq_st_o", int'(irq_st_o), int'(m_raw & m_ie));
        chk("R10", "zero_mode_o", int'(zero_mode_o), int'(m_zm));
    endtask

    // Present a count (and optional clear) for one cycle, then compare.
    task automatic step(input logic signed [15:0] v, input logic clr);
        count_i = v;
        irq_clr_i = clr;
        @(negedge clk);
        irq_clr_i = 1'b0;
        model(v, clr);
        compare();
    endtask

    task automatic wr_cfg(input logic [4:0] en, input logic signed [15:0] t0, t1, hl, ll,
                          input logic ie);
        cfg_cmp_en_i = en; cfg_thr0_i = t0; cfg_thr1_i = t1;
        cfg_hlim_i = hl; cfg_llim_i = ll; cfg_irq_en_i = ie; cfg_wr_i = 1'b1;
        @(negedge clk);
        cfg_wr_i = 1'b0;
        model(count_i, 1'b0);
        m_en = en; m_t0 = t0; m_t1 = t1; m_hl = hl; m_ll = ll; m_ie = ie;
    endtask

    initial begin
        m_prev = 0; m_t0 = 0; m_t1 = 0; m_hl = 0; m_ll = 0;
        m_en = 5'b00111; m_flags = 0; m_raw = 0; m_rst = 0; m_ie = 0; m_zm = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "flags after reset", int'(evt_flags_o), 0);
        chk("R1", "raw after reset", int'(irq_raw_o), 0);
        chk("R1", "st after reset", int'(irq_st_o), 0);
        chk("R1", "rst req after reset", int'(count_rst_o), 0);
        chk("R1", "zero mode after reset", int'(zero_mode_o), 0);

        // R1/R2: default enables, all values 0 -> zero, hlim, llim all hit
        step(16'sd5, 1'b0);
        step(16'sd0, 1'b0);
        chk("R1", "default flags on reaching 0", int'(evt_flags_o), 5'b00111);
        chk("R2", "limit reset request", int'(count_rst_o), 1);
        chk("R10", "fell to zero", int'(zero_mode_o), 0);
        // R3: staying on the value does not hit again
        step(16'sd0, 1'b0);
        chk("R3", "no repeat request", int'(count_rst_o), 0);
        // R8: clear
        step(16'sd0, 1'b1);
        chk("R8", "raw after clear", int'(irq_raw_o), 0);
        chk("R8", "flags after clear", int'(evt_flags_o), 0);
        // R10: rise to zero from negative
        step(-16'sd3, 1'b0);
        step(16'sd0, 1'b1);
        chk("R10", "rose to zero", int'(zero_mode_o), 1);

        // R11/R4: only thresholds enabled
        wr_cfg(5'b11000, 16'sd3, 16'sd9, 16'sd0, 16'sd0, 1'b1);
        step(16'sd0, 1'b1);
        step(-16'sd1, 1'b0);
        step(16'sd0, 1'b0);
        chk("R4", "disabled zero/limits no hit", int'(irq_raw_o), 0);
        step(16'sd3, 1'b0);
        chk("R11", "threshold0 flag", int'(evt_flags_o), 5'b01000);
        chk("R9", "masked status", int'(irq_st_o), 1);
        step(16'sd9, 1'b0);
        chk("R7", "flags held while pending", int'(evt_flags_o), 5'b01000);
        step(16'sd3, 1'b1);
        chk("R8", "hit wins over clear raw", int'(irq_raw_o), 1);
        chk("R8", "hit with clear flags", int'(evt_flags_o), 5'b01000);

        // Sweep all enable masks and both interrupt enables.
        for (int mask = 0; mask < 32; mask++) begin
            for (int ie = 0; ie < 2; ie++) begin
                wr_cfg(mask[4:0], 16'sd3, -16'sd2, 16'sd6, -16'sd4, ie[0]);
                step(count_i, 1'b1);
                for (int v = -6; v <= 8; v++) step(16'(v), ((v + 6) % 4) == 3);
                for (int v = 8; v >= -6; v--) step(16'(v), ((v + 6) % 5) == 0);
            end
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule